// File: doc/BRIEF.md
# Link Power State Request Gate

This block decides whether a serial storage link may enter one of its three low-power interface states: partial, slumber or device-sleep. Software writes a 4-bit restriction code into a register inside the block. Each of the low three bits of the code forbids one state. A code at or above 8h is reserved, and it forbids every state.

Requests reach the gate from two sides. The local power policy raises a host-side strobe together with the wanted state. The link layer raises a device-side strobe when the attached device asks for a state. An allowed request of either kind becomes a one-cycle grant pulse to the link layer. The pulse carries the state and a flag that tells which side the grant answers. A device request that the restriction forbids gets a one-cycle negative acknowledge instead. A forbidden host request is dropped without any output.

A device request always gets its answer one clock after its strobe. When both sides strobe in the same cycle, the device is served first. The host request is then held for one cycle and judged against the restriction in force at that later cycle. Software reads the current code and a sticky flag that records any write of a reserved code.

Top module: `lpm_entry_gate`

## Requirements
- R1: After reset, restrictCode is 0h, resvdErr is 0, and linkGrant and devNak are both 0.
- R2: Within codes 0h to 7h, bit 0 forbids partial (state 0), bit 1 forbids slumber (state 1) and bit 2 forbids device-sleep (state 2). A state whose bit is clear is allowed.
- R3: Any code from 8h to Fh forbids all three states.
- R4: Writing a code from 8h to Fh sets resvdErr. resvdErr then stays 1 until reset, even after a later write of a legal code.
- R5: A devReq strobe produces, in the next cycle, exactly one of two answers. One is linkGrant with grantFromDev=1 and linkGrantState equal to the requested state. The other is devNak. Neither output pulses without a devReq strobe behind it.
- R6: A device request for a forbidden state yields devNak and no grant.
- R7: A host request for an allowed state yields linkGrant with grantFromDev=0 in the next cycle. A host request for a forbidden state yields neither linkGrant nor devNak.
- R8: When hostReq and devReq strobe in the same cycle, the next cycle answers the device. The host request is granted or dropped one cycle later, judged against the code in force then.
- R9: A write takes effect for requests whose strobe arrives on the cycle after the write. A request in the same cycle as the write is judged against the previous code.
- R10: State code 3 is undefined and is never granted. From the device it draws devNak; from the host it is dropped.
- R11: restrictCode always shows the last value written through cfgWrEn and cfgWrData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the restriction register |
| cfgWrData | input | 4 | Restriction code to write |
| restrictCode | output | 4 | Current restriction code, for read-back |
| resvdErr | output | 1 | Sticky flag: a reserved code was written |
| hostReq | input | 1 | Host-side entry request strobe |
| hostState | input | 2 | Requested state on the host side (0 partial, 1 slumber, 2 device-sleep) |
| devReq | input | 1 | Device-side entry request strobe from the link layer |
| devState | input | 2 | Requested state on the device side |
| linkGrant | output | 1 | One-cycle grant pulse to the link layer |
| linkGrantState | output | 2 | State that the grant covers |
| grantFromDev | output | 1 | 1 when the grant answers a device request |
| devNak | output | 1 | One-cycle negative acknowledge to the device |

## Verification
The hardest case to reach is a deferred host request that meets a changed restriction. A host strobe has to collide with a device strobe, and a register write has to land on that same edge. Only then is the held request judged against the new code, not the one in force when it arrived. The collision task drives all three inputs in one cycle and checks the dropped or granted host answer one cycle after the device answer. The sweep task covers every code and every state code on both sides, so each reserved code is also checked against each state.

// File: rtl/lpm_gate_pkg.sv
package lpm_gate_pkg;
  localparam int CODE_W = 4;
  localparam int STATE_W = 2;
  localparam int NUM_STATES = 3;

  typedef struct packed {
    logic grantDev;
    logic nakDev;
    logic grantHost;
    logic dropHost;
    logic holdHost;
  } gateStrobe_t;

  function automatic logic stateAllowed(input logic [NUM_STATES-1:0] allowVec,
                                        input logic [STATE_W-1:0] st);
    logic ok;
    ok = 1'b0;
    for (int i = 0; i < NUM_STATES; i++) begin
      if (st == STATE_W'(i)) ok = allowVec[i];
    end
    return ok;
  endfunction
endpackage

// File: rtl/lpm_gate_ctrl.sv
module lpm_gate_ctrl
  import lpm_gate_pkg::*;
(
  input  logic        devReq,
  input  logic        devAllowed,
  input  logic        hostCand,
  input  logic        hostAllowed,
  output gateStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (devReq) begin
      strobe.grantDev = devAllowed;
      strobe.nakDev   = ~devAllowed;
      strobe.holdHost = hostCand;
    end else if (hostCand) begin
      strobe.grantHost = hostAllowed;
      strobe.dropHost  = ~hostAllowed;
    end
  end
endmodule

// File: rtl/lpm_gate_datapath.sv
module lpm_gate_datapath
  import lpm_gate_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int SW = STATE_W,
  parameter int NS = NUM_STATES
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [CW-1:0] cfgWrData,
  input  logic          hostReq,
  input  logic [SW-1:0] hostState,
  input  logic [SW-1:0] devState,
  input  gateStrobe_t   strobe,
  output logic          devAllowed,
  output logic          hostCand,
  output logic          hostAllowed,
  output logic [CW-1:0] restrictCode,
  output logic          resvdErr,
  output logic          linkGrant,
  output logic [SW-1:0] linkGrantState,
  output logic          grantFromDev,
  output logic          devNak
);
  localparam logic [CW-1:0] RESV_BASE = CW'(1 << NS);

  logic [CW-1:0] restrictQ;
  logic          errQ;
  logic          pendValid;
  logic [SW-1:0] pendState;
  logic [SW-1:0] candState;
  logic [NS-1:0] allowVec;

  assign allowVec    = (restrictQ >= RESV_BASE) ? '0 : ~restrictQ[NS-1:0];
  assign candState   = hostReq ? hostState : pendState;
  assign hostCand    = hostReq | pendValid;
  assign devAllowed  = stateAllowed(allowVec, devState);
  assign hostAllowed = stateAllowed(allowVec, candState);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      restrictQ <= '0;
      errQ      <= 1'b0;
    end else if (cfgWrEn) begin
      restrictQ <= cfgWrData;
      errQ      <= errQ | (cfgWrData >= RESV_BASE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendState <= '0;
    end else if (strobe.holdHost) begin
      pendValid <= 1'b1;
      pendState <= candState;
    end else if (strobe.grantHost | strobe.dropHost) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkGrant      <= 1'b0;
      linkGrantState <= '0;
      grantFromDev   <= 1'b0;
      devNak         <= 1'b0;
    end else begin
      linkGrant      <= strobe.grantDev | strobe.grantHost;
      linkGrantState <= strobe.grantDev ? devState : candState;
      grantFromDev   <= strobe.grantDev;
      devNak         <= strobe.nakDev;
    end
  end

  assign restrictCode = restrictQ;
  assign resvdErr     = errQ;
endmodule

// File: rtl/lpm_entry_gate.sv
module lpm_entry_gate
  import lpm_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CODE_W-1:0]  cfgWrData,
  output logic [CODE_W-1:0]  restrictCode,
  output logic               resvdErr,
  input  logic               hostReq,
  input  logic [STATE_W-1:0] hostState,
  input  logic               devReq,
  input  logic [STATE_W-1:0] devState,
  output logic               linkGrant,
  output logic [STATE_W-1:0] linkGrantState,
  output logic               grantFromDev,
  output logic               devNak
);
  gateStrobe_t strobe;
  logic devAllowed, hostCand, hostAllowed;

  lpm_gate_ctrl uCtrl (
    .devReq(devReq), .devAllowed(devAllowed),
    .hostCand(hostCand), .hostAllowed(hostAllowed), .strobe(strobe)
  );

  lpm_gate_datapath #(.CW(CODE_W), .SW(STATE_W), .NS(NUM_STATES)) uDp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .hostReq(hostReq), .hostState(hostState), .devState(devState),
    .strobe(strobe), .devAllowed(devAllowed), .hostCand(hostCand),
    .hostAllowed(hostAllowed), .restrictCode(restrictCode), .resvdErr(resvdErr),
    .linkGrant(linkGrant), .linkGrantState(linkGrantState),
    .grantFromDev(grantFromDev), .devNak(devNak)
  );
endmodule

// File: rtl/lpm_entry_gate_chk.sv
module lpm_entry_gate_chk
  import lpm_gate_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cfgWrEn,
  input logic [CODE_W-1:0]  cfgWrData,
  input logic [CODE_W-1:0]  restrictCode,
  input logic               resvdErr,
  input logic               hostReq,
  input logic               devReq,
  input logic [STATE_W-1:0] devState,
  input logic               linkGrant,
  input logic [STATE_W-1:0] linkGrantState,
  input logic               grantFromDev,
  input logic               devNak
);
  localparam logic [CODE_W-1:0] RESV = CODE_W'(1 << NUM_STATES);

  assert_one_answer_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(linkGrant && devNak));
  assert_dev_answered_R5: assert property (@(posedge clk) disable iff (!rstN)
    devReq |=> (devNak || (linkGrant && grantFromDev)));
  assert_nak_has_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    devNak |-> $past(devReq));
  assert_dev_grant_state_R5: assert property (@(posedge clk) disable iff (!rstN)
    (linkGrant && grantFromDev) |-> ($past(devReq) && linkGrantState == $past(devState)));
  assert_sticky_err_R4: assert property (@(posedge clk) disable iff (!rstN)
    resvdErr |=> resvdErr);
  assert_err_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrData >= RESV) |=> resvdErr);
  assert_reserved_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    linkGrant |-> ($past(restrictCode) < RESV));
  assert_device_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    (devReq && hostReq) |=> (!linkGrant || grantFromDev));
  assert_no_state3_R10: assert property (@(posedge clk) disable iff (!rstN)
    linkGrant |-> (linkGrantState != 2'd3));
endmodule

bind lpm_entry_gate lpm_entry_gate_chk uChk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .restrictCode(restrictCode), .resvdErr(resvdErr), .hostReq(hostReq),
  .devReq(devReq), .devState(devState), .linkGrant(linkGrant),
  .linkGrantState(linkGrantState), .grantFromDev(grantFromDev), .devNak(devNak)
);

// File: tb/lpm_entry_gate_test.sv
module lpm_entry_gate_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [3:0] cfgWrData = '0;
  logic [3:0] restrictCode;
  logic       resvdErr;
  logic       hostReq = 1'b0;
  logic [1:0] hostState = '0;
  logic       devReq = 1'b0;
  logic [1:0] devState = '0;
  logic       linkGrant;
  logic [1:0] linkGrantState;
  logic       grantFromDev;
  logic       devNak;

  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  lpm_entry_gate uut (.*);

  always #5 clk = ~clk;

  function automatic bit refAllowed(input logic [3:0] code, input logic [1:0] st);
    if (st == 2'd3) return 1'b0;
    if (code >= 4'h8) return 1'b0;
    return ~code[st];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
  endtask

  task automatic writeCode(input logic [3:0] c);
    cfgWrEn = 1'b1;
    cfgWrData = c;
    tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check(restrictCode == 4'h0, "R1 code", restrictCode, 0);
    check(resvdErr == 1'b0, "R1 err", resvdErr, 0);
    check(!linkGrant && !devNak, "R1 outputs", {linkGrant, devNak}, 0);
  endtask

  task automatic testSweep();
    for (int c = 0; c < 16; c++) begin
      writeCode(4'(c));
      check(restrictCode == 4'(c), "R11 readback", restrictCode, c);
      for (int s = 0; s < 4; s++) begin
        bit ok;
        ok = refAllowed(4'(c), 2'(s));
        devReq = 1'b1;
        devState = 2'(s);
        tick();
        devReq = 1'b0;
        // R2 R3 R6 R10 device answer
        check(linkGrant == ok && devNak == !ok && (!ok || (grantFromDev && linkGrantState == 2'(s))),
              "R5/R6 device answer", {linkGrant, devNak}, {ok, !ok});
        hostReq = 1'b1;
        hostState = 2'(s);
        tick();
        hostReq = 1'b0;
        // R2 R3 R7 R10 host answer
        check(linkGrant == ok && !devNak && (!ok || (!grantFromDev && linkGrantState == 2'(s))),
              "R7 host answer", {linkGrant, devNak}, {ok, 1'b0});
      end
    end
  endtask

  task automatic testSticky();
    doReset();
    writeCode(4'h5);
    check(resvdErr == 1'b0, "R4 legal write", resvdErr, 0);
    writeCode(4'hA);
    check(resvdErr == 1'b1, "R4 reserved write", resvdErr, 1);
    writeCode(4'h0);
    check(resvdErr == 1'b1, "R4 sticky", resvdErr, 1);
    check(restrictCode == 4'h0, "R11 readback", restrictCode, 0);
  endtask

  task automatic testCollision();
    doReset();
    devReq = 1'b1; devState = 2'd1;
    hostReq = 1'b1; hostState = 2'd2;
    tick();
    devReq = 1'b0; hostReq = 1'b0;
    check(linkGrant && grantFromDev && linkGrantState == 2'd1, "R8 device first",
          linkGrantState, 1);
    tick();
    check(linkGrant && !grantFromDev && linkGrantState == 2'd2, "R8 host deferred",
          {linkGrant, grantFromDev}, 2);
    tick();
    check(!linkGrant && !devNak, "R8 idle after", {linkGrant, devNak}, 0);
    // collision while a write forbids the held host state
    devReq = 1'b1; devState = 2'd0;
    hostReq = 1'b1; hostState = 2'd0;
    cfgWrEn = 1'b1; cfgWrData = 4'h1;
    tick();
    devReq = 1'b0; hostReq = 1'b0; cfgWrEn = 1'b0;
    check(linkGrant && grantFromDev, "R8 R9 device judged on old code", linkGrant, 1);
    tick();
    check(!linkGrant && !devNak, "R8 held host judged on new code", {linkGrant, devNak}, 0);
  endtask

  task automatic testWriteTiming();
    doReset();
    devReq = 1'b1; devState = 2'd2;
    cfgWrEn = 1'b1; cfgWrData = 4'h4;
    tick();
    devReq = 1'b0; cfgWrEn = 1'b0;
    check(linkGrant && !devNak, "R9 same-cycle old code", linkGrant, 1);
    devReq = 1'b1; devState = 2'd2;
    tick();
    devReq = 1'b0;
    check(devNak && !linkGrant, "R9 next-cycle new code", devNak, 1);
    hostReq = 1'b1; hostState = 2'd3;
    tick();
    hostReq = 1'b0;
    check(!linkGrant && !devNak, "R10 host state3 dropped", linkGrant, 0);
  endtask

  initial begin
    testReset();
    testSweep();
    testSticky();
    testCollision();
    testWriteTiming();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checkCount++;
        failCount++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule